// File: doc/BRIEF.md
# Cascadable Dual Byte Pulse Counter

This block holds two byte-wide event counters. Each one steps on a single-cycle strobe that is already synchronous to the block clock. In split mode the two bytes are unrelated counters, and each has its own strobe. In linked mode they form one 16-bit counter. The strobe of the low byte drives the whole word, and the upper byte steps on the carry out of the lower byte. A sticky overflow flag records every wrap of the upper byte.

Software reaches the counters through a small address-decoded port. The port offers byte access to each half, a word access that reads or writes both halves on the same clock edge, and a flag location that is cleared by writing a one. Read data is combinational. A bus write always takes precedence over a strobe in the same cycle.

Top module: `pulse_acc_pair`

## Requirements
- R1: After an asynchronous active-low reset, both count bytes and the overflow flag read as zero.
- R2: When `link_en` is 0 and `split_en` is 1, `pulse_lo` adds one (mod 256) to the low byte and `pulse_hi` adds one (mod 256) to the high byte. The two bytes are independent.
- R3: When `link_en` is 1, the counter {high,low} is one 16-bit value. `pulse_lo` adds one to it, so the high byte steps only when the low byte rolls from 0xFF to 0x00. `pulse_hi` is ignored. `link_en` takes precedence over `split_en`.
- R4: When both `link_en` and `split_en` are 0, strobes change no count.
- R5: Address 0 is the word location. The read returns {high,low} on `rdata[15:0]` in the same cycle. `wr16` at address 0 loads high from `wdata[15:8]` and low from `wdata[7:0]` on a single edge.
- R6: Address 1 is the low byte and address 2 is the high byte. They read zero-extended on `rdata`, and `wr8` writes `wdata[7:0]` into them. Address 3 reads the flag in `rdata[0]`. A `wr8` at address 0 and a `wr16` at addresses 1 to 3 have no effect.
- R7: When a byte is written in the same cycle as its increment, the written value is stored and the increment is lost. In linked mode, a write to the low byte also suppresses the carry into the high byte.
- R8: The overflow flag sets when the high byte steps from 0xFF to 0x00 by counting, in either mode. A write never sets the flag.
- R9: The flag holds until `wr8` at address 3 with `wdata[0]`=1 clears it. A wrap in the same cycle as that clear leaves the flag set.
- R10: A read of the two bytes one at a time, across a carry, gives a value different from a single word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Joins the two bytes into one 16-bit counter |
| split_en | input | 1 | Lets the two bytes count separately while not linked |
| pulse_lo | input | 1 | Single-cycle strobe for the low byte (or for the word when linked) |
| pulse_hi | input | 1 | Single-cycle strobe for the high byte in split mode |
| addr | input | 2 | Register address: 0 word, 1 low, 2 high, 3 flag |
| wr8 | input | 1 | Byte write strobe |
| wr16 | input | 1 | Word write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for `addr` |

## Verification
The assertions assume that strobes and write enables are sampled only at rising edges, and that every input is known and stable around each edge. The bench changes all inputs on the falling edge, so this assumption holds. It also drives only the defined address codes. Random phases mix strobes with writes to every location. This makes the coincidences that the properties single out occur often, such as a write on top of a strobe, a carry on top of a high-byte write, and a wrap on top of a flag clear.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
    typedef enum logic [1:0] {
        LOC_WORD = 2'd0,
        LOC_LO   = 2'd1,
        LOC_HI   = 2'd2,
        LOC_FLAG = 2'd3
    } pacc_loc_e;

    typedef struct packed {
        logic ovf;
    } pacc_flag_t;
endpackage

// File: rtl/pacc_byte.sv
module pacc_byte #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wd,
    output logic [BYTE_W-1:0] q,
    output logic              wrap
);
    localparam logic [BYTE_W-1:0] STEP = BYTE_W'(1);

    typedef struct packed {
        logic [BYTE_W-1:0] cnt;
    } slice_t;

    slice_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.cnt = wd;
        end else if (inc) begin
            st_d.cnt = st_q.cnt + STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q    = st_q.cnt;
    assign wrap = inc & ~wr & (&st_q.cnt);

    // R7: the write value is stored even when an increment coincides
    assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> q == $past(wd));
    // R2: one step per accepted increment
    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr) |=> q == $past(q) + STEP);
    // R4: no activity keeps the count
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr) |=> $stable(q));
endmodule

// File: rtl/pacc_regif.sv
module pacc_regif
    import pacc_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic [1:0]        addr,
    input  logic              wr8,
    input  logic              wr16,
    input  logic [WORD_W-1:0] wdata,
    input  logic [BYTE_W-1:0] lo_q,
    input  logic [BYTE_W-1:0] hi_q,
    input  logic              flag_q,
    output logic              wr_lo,
    output logic              wr_hi,
    output logic [BYTE_W-1:0] wd_lo,
    output logic [BYTE_W-1:0] wd_hi,
    output logic              clr_flag,
    output logic [WORD_W-1:0] rdata
);
    pacc_loc_e loc;
    assign loc = pacc_loc_e'(addr);

    always_comb begin
        wr_lo    = 1'b0;
        wr_hi    = 1'b0;
        wd_lo    = wdata[BYTE_W-1:0];
        wd_hi    = wdata[BYTE_W-1:0];
        clr_flag = 1'b0;
        rdata    = '0;
        unique case (loc)
            LOC_WORD: begin
                rdata = {hi_q, lo_q};
                wr_lo = wr16;
                wr_hi = wr16;
                wd_hi = wdata[WORD_W-1:BYTE_W];
            end
            LOC_LO: begin
                rdata = {{BYTE_W{1'b0}}, lo_q};
                wr_lo = wr8;
            end
            LOC_HI: begin
                rdata = {{BYTE_W{1'b0}}, hi_q};
                wr_hi = wr8;
            end
            LOC_FLAG: begin
                rdata    = {{(WORD_W-1){1'b0}}, flag_q};
                clr_flag = wr8 & wdata[0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pulse_acc_pair.sv
module pulse_acc_pair
    import pacc_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_en,
    input  logic              split_en,
    input  logic              pulse_lo,
    input  logic              pulse_hi,
    input  logic [1:0]        addr,
    input  logic              wr8,
    input  logic              wr16,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int NSLICE = 2;
    localparam logic [BYTE_W-1:0] STEP = BYTE_W'(1);

    logic              s_inc  [NSLICE];
    logic              s_wr   [NSLICE];
    logic [BYTE_W-1:0] s_wd   [NSLICE];
    logic [BYTE_W-1:0] s_q    [NSLICE];
    logic              s_wrap [NSLICE];
    logic              clr_flag;

    pacc_flag_t fl_d, fl_q;

    pacc_regif #(.BYTE_W(BYTE_W)) u_regif (
        .addr     (addr),
        .wr8      (wr8),
        .wr16     (wr16),
        .wdata    (wdata),
        .lo_q     (s_q[0]),
        .hi_q     (s_q[1]),
        .flag_q   (fl_q.ovf),
        .wr_lo    (s_wr[0]),
        .wr_hi    (s_wr[1]),
        .wd_lo    (s_wd[0]),
        .wd_hi    (s_wd[1]),
        .clr_flag (clr_flag),
        .rdata    (rdata)
    );

    // slice 0 is the low byte, slice 1 the high byte
    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        pacc_byte #(.BYTE_W(BYTE_W)) u_byte (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (s_inc[g]),
            .wr    (s_wr[g]),
            .wd    (s_wd[g]),
            .q     (s_q[g]),
            .wrap  (s_wrap[g])
        );
    end

    always_comb begin
        if (link_en) begin
            s_inc[0] = pulse_lo;
            s_inc[1] = s_wrap[0];
        end else begin
            s_inc[0] = split_en & pulse_lo;
            s_inc[1] = split_en & pulse_hi;
        end
    end

    always_comb begin
        fl_d = fl_q;
        if (s_wrap[1]) begin
            fl_d.ovf = 1'b1;
        end else if (clr_flag) begin
            fl_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    // R3: a low-byte rollover carries into the high byte
    assert_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && pulse_lo && (&s_q[0]) && !s_wr[0] && !s_wr[1])
        |=> s_q[1] == $past(s_q[1]) + STEP);
    // R3: the high byte does not step on its own strobe when linked
    assert_hi_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && !(pulse_lo && (&s_q[0])) && !s_wr[1]) |=> $stable(s_q[1]));
    // R4: both modes off leaves the counts alone
    assert_off_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_en && !split_en && !s_wr[0] && !s_wr[1])
        |=> ($stable(s_q[0]) && $stable(s_q[1])));
    // R8: a counted high-byte wrap raises the flag
    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((&s_q[1]) && s_inc[1] && !s_wr[1]) |=> fl_q.ovf);
    // R9: the flag is sticky without a clear
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.ovf && !clr_flag) |=> fl_q.ovf);
    // R9: a clear without a wrap drops the flag
    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flag && !s_wrap[1]) |=> !fl_q.ovf);
endmodule

// File: tb/pulse_acc_pair_tb.sv
module pulse_acc_pair_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_en = 1'b0, split_en = 1'b0;
    logic        pulse_lo = 1'b0, pulse_hi = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        wr8 = 1'b0, wr16 = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int n_cmp = 0, n_bad = 0, n_cyc = 0;
    int m_lo = 0, m_hi = 0, m_fl = 0;
    string tag = "R1";
    logic [15:0] last_rd;

    always #5 clk = ~clk;

    pulse_acc_pair u_dut (
        .clk(clk), .rst_n(rst_n), .link_en(link_en), .split_en(split_en),
        .pulse_lo(pulse_lo), .pulse_hi(pulse_hi), .addr(addr),
        .wr8(wr8), .wr16(wr16), .wdata(wdata), .rdata(rdata)
    );

    function automatic int model_read(input int a);
        case (a)
            0: return m_hi * 256 + m_lo;
            1: return m_lo;
            2: return m_hi;
            default: return m_fl;
        endcase
    endfunction

    function automatic void model_step();
        bit w_lo, w_hi, clr, i_lo, i_hi, wrp;
        int n_lo, n_hi;
        w_lo = (wr16 && addr == 0) || (wr8 && addr == 1);
        w_hi = (wr16 && addr == 0) || (wr8 && addr == 2);
        clr  = wr8 && addr == 3 && wdata[0];
        if (link_en) begin
            i_lo = pulse_lo;
            i_hi = pulse_lo && !w_lo && m_lo == 255;
        end else begin
            i_lo = split_en && pulse_lo;
            i_hi = split_en && pulse_hi;
        end
        n_lo = w_lo ? int'(wdata[7:0]) : (i_lo ? (m_lo + 1) % 256 : m_lo);
        n_hi = w_hi ? (wr16 ? int'(wdata[15:8]) : int'(wdata[7:0]))
                    : (i_hi ? (m_hi + 1) % 256 : m_hi);
        wrp  = i_hi && !w_hi && m_hi == 255;
        if (wrp) m_fl = 1;
        else if (clr) m_fl = 0;
        m_lo = n_lo;
        m_hi = n_hi;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // apply inputs now (at a falling edge), run one clock, compare at next falling edge
    task automatic cyc(input bit lk, input bit sp, input bit pl, input bit ph,
                       input int a, input bit w8, input bit w16, input int wd);
        link_en = lk; split_en = sp; pulse_lo = pl; pulse_hi = ph;
        addr = 2'(a); wr8 = w8; wr16 = w16; wdata = 16'(wd);
        @(posedge clk);
        #1;
        if (rst_n) model_step();
        else begin m_lo = 0; m_hi = 0; m_fl = 0; end
        @(negedge clk);
        last_rd = rdata;
        check(tag, int'(rdata), model_read(a));
    endtask

    task automatic rnd_phase(input int n, input int lk, input int sp, input bit writes);
        for (int i = 0; i < n; i++) begin
            int a, op;
            bit w8v, w16v;
            a = $urandom_range(0, 3);
            op = writes ? $urandom_range(0, 9) : 9;
            w8v = (op < 2);
            w16v = (op == 2) && a == 0;
            cyc(lk < 0 ? 1'($urandom_range(0, 1)) : 1'(lk),
                sp < 0 ? 1'($urandom_range(0, 1)) : 1'(sp),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                a, w8v, w16v, (op == 0 && $urandom_range(0, 3) == 0) ? 16'hFFFF
                              : int'($urandom_range(0, 65535)));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        int comp;
        @(negedge clk);
        tag = "R1";
        for (int i = 0; i < 4; i++) cyc(1, 1, 1, 1, i, 0, 0, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, i, 0, 0, 0);

        tag = "R2";  rnd_phase(400, 0, 1, 0);
        tag = "R4";  rnd_phase(100, 0, 0, 0);

        tag = "R5";
        cyc(0, 0, 0, 0, 0, 0, 1, 16'h12FE);
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        tag = "R6";
        cyc(0, 0, 0, 0, 1, 1, 0, 16'hAA5C);
        cyc(0, 0, 0, 0, 2, 1, 0, 16'h5533);
        cyc(0, 0, 0, 0, 0, 1, 0, 16'h7777);  // byte strobe at word location: no effect
        cyc(0, 0, 0, 0, 2, 0, 1, 16'h7777);  // word strobe at high location: no effect
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        check("R6", int'(last_rd), 16'h335C);

        tag = "R3";
        cyc(1, 0, 0, 0, 0, 0, 1, 16'hFEF0);
        rnd_phase(600, 1, -1, 0);
        tag = "R8";
        cyc(1, 0, 0, 0, 0, 0, 1, 16'hFFFF);
        cyc(1, 0, 1, 0, 3, 0, 0, 0);
        check("R8", int'(last_rd), 1);

        tag = "R9";
        cyc(1, 0, 0, 0, 3, 1, 0, 0);         // write of zero keeps flag
        cyc(1, 0, 0, 0, 3, 1, 0, 1);         // write of one clears
        check("R9", int'(last_rd), 0);
        cyc(1, 0, 0, 0, 0, 0, 1, 16'hFFFF);
        cyc(1, 0, 1, 0, 3, 1, 0, 1);         // wrap and clear together
        check("R9", int'(last_rd), 1);

        tag = "R7";
        cyc(0, 1, 1, 1, 0, 0, 1, 16'h4080);
        check("R7", int'(last_rd), 16'h4080);
        cyc(1, 0, 0, 0, 0, 0, 1, 16'h10FF);
        cyc(1, 0, 1, 0, 1, 1, 0, 16'h0011);  // low write kills increment and carry
        cyc(1, 0, 0, 0, 0, 0, 0, 0);
        check("R7", int'(last_rd), 16'h1011);

        tag = "R10";
        cyc(1, 0, 0, 0, 0, 0, 1, 16'h00FF);
        cyc(1, 0, 0, 0, 1, 0, 0, 0);
        comp = int'(last_rd[7:0]);
        cyc(1, 0, 1, 0, 2, 0, 0, 0);
        comp = comp + 256 * int'(last_rd[7:0]);
        cyc(1, 0, 0, 0, 0, 0, 0, 0);
        check("R10", comp, 16'h01FF);
        check("R10", int'(last_rd), 16'h0100);

        tag = "R6";  rnd_phase(3000, -1, -1, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule